// File: doc/BRIEF.md
# Bus Lock Guard for Read-Modify-Write Instructions

This block sits behind an instruction decoder. It watches the stream of prefix bytes for the lock prefix code, 0xF0. It remembers that prefix until the next instruction begins. When that instruction begins, the block checks the decoded operation class and operand form against a fixed list of read-modify-write operations that have a memory destination.

A lockable instruction drives the active-low bus lock output. The output stays low from the cycle after the instruction starts until the instruction's done strobe, so other bus masters cannot touch shared memory in the middle of the update. A prefix on any other operation does not drive the lock. Instead it produces a one-cycle undefined-opcode exception request, with a vector number and a flag that tells a fault apart from a plain real-mode interrupt. An exchange between a register and memory always locks the bus, even without the prefix.

Operand alignment plays no part in the decision. Only the prefix, the class and the form matter, so a misaligned memory operand still gets the lock.

Top module: `buslock_guard`

## Requirements
- R1: While rst_n is low, bus_lock_n is 1, exc_req is 0 and exc_fault is 0. A lock prefix byte seen before reset is discarded, so a lockable instruction started after reset without a new prefix does not lock.
- R2: A byte on pfx_byte with pfx_vld high sets the pending prefix only when its value is 0xF0. Any other value is ignored. A prefix byte in the same cycle as insn_start applies to that instruction. The pending prefix is used up by the next insn_start only, so the instruction after it is not locked.
- R3: With the prefix, the classes bit-test 1, bit-test-set 2, bit-test-reset 3, bit-test-complement 4, add 6, or 7, add-carry 8, sub-borrow 9, and 10, sub 11 and xor 12 are lockable when the form is memory-dest/register-src (1) or memory-dest/immediate (2). For these, bus_lock_n is 0 from the cycle after the insn_start edge up to and including the cycle that carries insn_done. It returns to 1 in the cycle after insn_done.
- R4: With the prefix, exchange (class 5) is lockable with form 1 or register-dest/memory-src (3).
- R5: With the prefix, not 13, negate 14, increment 15 and decrement 16 are lockable with the single-memory-operand form (4).
- R6: A prefixed instruction whose class and form are not in R3 to R5 raises exc_req for exactly the one cycle after the insn_start edge. bus_lock_n stays 1. This covers every other class (0, 17 to 31) and forms 0 register-register, 5 register only, 6 register-immediate and 7 none.
- R7: An exchange (class 5) with form 1 or 3 locks exactly as in R3 even without the prefix, and raises no exception.
- R8: When exc_req is 1, exc_vec equals 6. exc_fault is 1 if cpu_mode at insn_start was protected (1), virtual-8086 (2) or 3, and 0 if it was real (0). When exc_req is 0, exc_vec is 0.
- R9: When insn_start and insn_done arrive in the same cycle, the new instruction alone decides the lock. A lock is never carried into an instruction that does not itself qualify.
- R10: Without the prefix, any instruction other than an exchange with memory leaves bus_lock_n at 1 and exc_req at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfx_vld | input | 1 | A prefix byte is presented this cycle |
| pfx_byte | input | 8 | Prefix byte value |
| insn_start | input | 1 | First cycle of an instruction; class, form and mode valid |
| op_class | input | 5 | Decoded operation class code |
| op_form | input | 3 | Operand form code |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086 |
| insn_done | input | 1 | Last cycle of the current instruction |
| bus_lock_n | output | 1 | Active-low bus lock |
| exc_req | output | 1 | Undefined-opcode exception request pulse |
| exc_vec | output | 8 | Exception vector number |
| exc_fault | output | 1 | 1 = fault (protected/virtual-8086), 0 = real-mode interrupt |

## Verification
Every result is registered. The lock level and the exception pulse with its vector and fault flag appear in the cycle after the clock edge that samples insn_start. The lock release appears in the cycle after the edge that samples insn_done, and a prefix byte takes effect at the next insn_start edge. The bench drives inputs on falling edges and updates a behavioural model on rising edges. It compares all outputs on every falling edge, so each comparison sees exactly one rising edge of latency. Directed sequences add named checks at those same points for each requirement, including same-cycle start and done, and a prefix byte that arrives together with insn_start.

// File: rtl/buslock_pkg.sv
package buslock_pkg;
  localparam int CLS_W  = 5;
  localparam int FORM_W = 3;
  localparam int MODE_W = 2;
  localparam int BYTE_W = 8;
  localparam int VEC_W  = 8;

  localparam logic [CLS_W-1:0] OC_BT   = 5'd1;
  localparam logic [CLS_W-1:0] OC_BTS  = 5'd2;
  localparam logic [CLS_W-1:0] OC_BTR  = 5'd3;
  localparam logic [CLS_W-1:0] OC_BTC  = 5'd4;
  localparam logic [CLS_W-1:0] OC_XCHG = 5'd5;
  localparam logic [CLS_W-1:0] OC_ADD  = 5'd6;
  localparam logic [CLS_W-1:0] OC_XOR  = 5'd12;
  localparam logic [CLS_W-1:0] OC_NOT  = 5'd13;
  localparam logic [CLS_W-1:0] OC_DEC  = 5'd16;

  localparam logic [FORM_W-1:0] OF_MEM_REG = 3'd1;
  localparam logic [FORM_W-1:0] OF_MEM_IMM = 3'd2;
  localparam logic [FORM_W-1:0] OF_REG_MEM = 3'd3;
  localparam logic [FORM_W-1:0] OF_MEM     = 3'd4;

  localparam logic [MODE_W-1:0] MODE_REAL = 2'd0;

  // bit-test family
  function automatic logic is_bit_cls(input logic [CLS_W-1:0] c);
    return (c >= OC_BT) && (c <= OC_BTC);
  endfunction

  // two-operand arithmetic/logic family
  function automatic logic is_alu_cls(input logic [CLS_W-1:0] c);
    return (c >= OC_ADD) && (c <= OC_XOR);
  endfunction

  // single-operand family
  function automatic logic is_unary_cls(input logic [CLS_W-1:0] c);
    return (c >= OC_NOT) && (c <= OC_DEC);
  endfunction

  function automatic logic mem_dst_src(input logic [FORM_W-1:0] f);
    return (f == OF_MEM_REG) || (f == OF_MEM_IMM);
  endfunction

  function automatic logic xchg_with_mem(input logic [CLS_W-1:0] c,
                                         input logic [FORM_W-1:0] f);
    return (c == OC_XCHG) && ((f == OF_MEM_REG) || (f == OF_REG_MEM));
  endfunction

  function automatic logic lock_allowed(input logic [CLS_W-1:0] c,
                                        input logic [FORM_W-1:0] f);
    logic ok;
    ok = 1'b0;
    if ((is_bit_cls(c) || is_alu_cls(c)) && mem_dst_src(f)) ok = 1'b1;
    if (xchg_with_mem(c, f)) ok = 1'b1;
    if (is_unary_cls(c) && (f == OF_MEM)) ok = 1'b1;
    return ok;
  endfunction
endpackage

// File: rtl/blk_pfx_track.sv
module blk_pfx_track
  import buslock_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PFX_CODE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              insn_start,
  output logic              pend_q,
  output logic              pfx_eff
);
  logic hit_now;

  assign hit_now = byte_vld && (byte_val == PFX_CODE);
  assign pfx_eff = pend_q || hit_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (insn_start) pend_q <= 1'b0;
    else if (hit_now)    pend_q <= 1'b1;
  end
endmodule

// File: rtl/blk_legal.sv
module blk_legal
  import buslock_pkg::*;
(
  input  logic [CLS_W-1:0]  op_class,
  input  logic [FORM_W-1:0] op_form,
  input  logic              pfx_eff,
  output logic              legal,
  output logic              implicit_lock,
  output logic              want_lock,
  output logic              trap_now
);
  assign legal         = lock_allowed(op_class, op_form);
  assign implicit_lock = xchg_with_mem(op_class, op_form);
  assign want_lock     = implicit_lock || (pfx_eff && legal);
  assign trap_now      = pfx_eff && !legal;
endmodule

// File: rtl/blk_lock_hold.sv
module blk_lock_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic insn_start,
  input  logic insn_done,
  input  logic want_lock,
  output logic lock_q
);
  // a new instruction overrides any release of the previous one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lock_q <= 1'b0;
    else if (insn_start) lock_q <= want_lock;
    else if (insn_done)  lock_q <= 1'b0;
  end
endmodule

// File: rtl/blk_exc_gen.sv
module blk_exc_gen
  import buslock_pkg::*;
#(
  parameter int UD_VEC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_start,
  input  logic              trap_now,
  input  logic [MODE_W-1:0] cpu_mode,
  output logic              exc_q,
  output logic              fault_q,
  output logic [VEC_W-1:0]  vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      exc_q   <= insn_start && trap_now;
      fault_q <= insn_start && trap_now && (cpu_mode != MODE_REAL);
    end
  end

  assign vec = exc_q ? VEC_W'(UD_VEC) : '0;
endmodule

// File: rtl/buslock_guard.sv
module buslock_guard
  import buslock_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PFX_CODE = 8'hF0,
  parameter int                UD_VEC   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfx_vld,
  input  logic [BYTE_W-1:0] pfx_byte,
  input  logic              insn_start,
  input  logic [CLS_W-1:0]  op_class,
  input  logic [FORM_W-1:0] op_form,
  input  logic [MODE_W-1:0] cpu_mode,
  input  logic              insn_done,
  output logic              bus_lock_n,
  output logic              exc_req,
  output logic [VEC_W-1:0]  exc_vec,
  output logic              exc_fault
);
  logic pend_q, pfx_eff;
  logic legal, implicit_lock, want_lock, trap_now;
  logic lock_q, exc_q, fault_q;

  blk_pfx_track #(.PFX_CODE(PFX_CODE)) u_pfx (
    .clk(clk), .rst_n(rst_n), .byte_vld(pfx_vld), .byte_val(pfx_byte),
    .insn_start(insn_start), .pend_q(pend_q), .pfx_eff(pfx_eff)
  );

  blk_legal u_legal (
    .op_class(op_class), .op_form(op_form), .pfx_eff(pfx_eff),
    .legal(legal), .implicit_lock(implicit_lock),
    .want_lock(want_lock), .trap_now(trap_now)
  );

  blk_lock_hold u_hold (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start),
    .insn_done(insn_done), .want_lock(want_lock), .lock_q(lock_q)
  );

  blk_exc_gen #(.UD_VEC(UD_VEC)) u_exc (
    .clk(clk), .rst_n(rst_n), .insn_start(insn_start),
    .trap_now(trap_now), .cpu_mode(cpu_mode),
    .exc_q(exc_q), .fault_q(fault_q), .vec(exc_vec)
  );

  assign bus_lock_n = !lock_q;
  assign exc_req    = exc_q;
  assign exc_fault  = fault_q;
endmodule

// File: rtl/buslock_guard_chk.sv
module buslock_guard_chk
  import buslock_pkg::*;
#(
  parameter int UD_VEC = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_start,
  input logic             insn_done,
  input logic             bus_lock_n,
  input logic             exc_req,
  input logic [VEC_W-1:0] exc_vec,
  input logic             pend_q,
  input logic             implicit_lock,
  input logic             trap_now
);
  p_pend_used_r2: assert property (@(posedge clk) disable iff (!rst_n)
    insn_start |=> !pend_q);

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !insn_start) |=> bus_lock_n);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_lock_n && !insn_done && !insn_start) |=> !bus_lock_n);

  p_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_start && trap_now) |=> (exc_req && bus_lock_n));

  p_trap_nolock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> bus_lock_n);

  p_xchg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_start && implicit_lock) |=> (!bus_lock_n && !exc_req));

  p_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_vec == VEC_W'(UD_VEC)));

  p_pulse_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(insn_start));
endmodule

bind buslock_guard buslock_guard_chk #(.UD_VEC(UD_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_start(insn_start), .insn_done(insn_done),
  .bus_lock_n(bus_lock_n), .exc_req(exc_req), .exc_vec(exc_vec),
  .pend_q(pend_q), .implicit_lock(implicit_lock), .trap_now(trap_now)
);

// File: tb/buslock_guard_test.sv
module buslock_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pfx_vld = 1'b0;
  logic [7:0] pfx_byte = 8'h00;
  logic       insn_start = 1'b0;
  logic [4:0] op_class = 5'd0;
  logic [2:0] op_form = 3'd0;
  logic [1:0] cpu_mode = 2'd0;
  logic       insn_done = 1'b0;
  logic       bus_lock_n, exc_req, exc_fault;
  logic [7:0] exc_vec;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  buslock_guard uut (
    .clk(clk), .rst_n(rst_n), .pfx_vld(pfx_vld), .pfx_byte(pfx_byte),
    .insn_start(insn_start), .op_class(op_class), .op_form(op_form),
    .cpu_mode(cpu_mode), .insn_done(insn_done), .bus_lock_n(bus_lock_n),
    .exc_req(exc_req), .exc_vec(exc_vec), .exc_fault(exc_fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference legality, written as class masks
  function automatic bit ref_ok(input int c, input int f);
    bit [31:0] two_op = 32'h0000_1FDE;
    bit [31:0] one_op = 32'h0001_E000;
    if (c == 5) return (f == 1) || (f == 3);
    if (two_op[c]) return (f == 1) || (f == 2);
    if (one_op[c]) return f == 4;
    return 0;
  endfunction

  bit m_pend = 0, m_lock = 0, m_exc = 0, m_fault = 0;

  always @(posedge clk) begin
    bit hit, eff, xm;
    if (!rst_n) begin
      m_pend = 0; m_lock = 0; m_exc = 0; m_fault = 0;
    end else begin
      hit = pfx_vld && (pfx_byte == 8'hF0);
      eff = m_pend || hit;
      xm  = (op_class == 5'd5) && (op_form == 3'd1 || op_form == 3'd3);
      if (insn_start) begin
        m_lock  = xm || (eff && ref_ok(op_class, op_form));
        m_exc   = eff && !ref_ok(op_class, op_form);
        m_fault = m_exc && (cpu_mode != 2'd0);
        m_pend  = 0;
      end else begin
        if (insn_done) m_lock = 0;
        m_exc = 0; m_fault = 0;
        if (hit) m_pend = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // model comparison every cycle
  always @(negedge clk) begin
    chk(bus_lock_n == !m_lock, "R3 lock level", bus_lock_n, !m_lock);
    chk(exc_req == m_exc, "R6 exc_req", exc_req, m_exc);
    chk(exc_fault == m_fault, "R8 exc_fault", exc_fault, m_fault);
    chk(exc_vec == (m_exc ? 8'd6 : 8'd0), "R8 exc_vec", exc_vec, m_exc ? 6 : 0);
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic run_insn(input bit pfx, input int c, input int f, input int m,
                          input int body, input bit exp_lock, input bit exp_exc,
                          input string tag);
    if (pfx) begin
      @(negedge clk); pfx_vld = 1; pfx_byte = 8'hF0;
    end
    @(negedge clk); pfx_vld = 0;
    insn_start = 1; op_class = 5'(c); op_form = 3'(f); cpu_mode = 2'(m);
    @(negedge clk); insn_start = 0;
    chk(bus_lock_n == !exp_lock, tag, bus_lock_n, !exp_lock);
    chk(exc_req == exp_exc, tag, exc_req, exp_exc);
    if (exp_exc) chk(exc_fault == (m != 0), {tag, " R8"}, exc_fault, m != 0);
    for (int i = 0; i < body; i++) begin
      @(negedge clk);
      chk(bus_lock_n == !exp_lock, tag, bus_lock_n, !exp_lock);
    end
    insn_done = 1;
    @(negedge clk); insn_done = 0;
    chk(bus_lock_n == 1'b1, {tag, " release"}, bus_lock_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_lock_n == 1'b1 && exc_req == 1'b0 && exc_fault == 1'b0,
        "R1 reset idle", {bus_lock_n, exc_req, exc_fault}, 3'b100);
    rst_n = 1;

    // R1: prefix seen then reset discards it
    @(negedge clk); pfx_vld = 1; pfx_byte = 8'hF0;
    @(negedge clk); pfx_vld = 0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    run_insn(0, 6, 1, 1, 1, 0, 0, "R1 prefix dropped by reset");

    run_insn(1, 6, 1, 1, 3, 1, 0, "R3 add mem,reg");
    run_insn(1, 2, 2, 0, 2, 1, 0, "R3 bts mem,imm");
    run_insn(1, 12, 1, 1, 1, 1, 0, "R3 xor mem,reg");

    // R2: other byte values are not the prefix
    @(negedge clk); pfx_vld = 1; pfx_byte = 8'hF3;
    run_insn(0, 6, 1, 1, 1, 0, 0, "R2 byte F3 ignored");
    // R2: prefix consumed by one instruction
    run_insn(1, 11, 2, 1, 1, 1, 0, "R2 first consumes");
    run_insn(0, 11, 2, 1, 1, 0, 0, "R2 second not locked");
    // R2: prefix byte together with insn_start
    @(negedge clk);
    pfx_vld = 1; pfx_byte = 8'hF0; insn_start = 1; op_class = 5'd15; op_form = 3'd4;
    @(negedge clk); pfx_vld = 0; insn_start = 0;
    chk(bus_lock_n == 1'b0, "R2 same-cycle prefix", bus_lock_n, 0);
    insn_done = 1; @(negedge clk); insn_done = 0;

    run_insn(1, 5, 3, 1, 2, 1, 0, "R4 xchg reg,mem prefixed");
    run_insn(1, 5, 1, 2, 1, 1, 0, "R4 xchg mem,reg prefixed");
    run_insn(1, 14, 4, 1, 2, 1, 0, "R5 neg mem");
    run_insn(1, 16, 4, 0, 1, 1, 0, "R5 dec mem");

    run_insn(1, 6, 3, 1, 1, 0, 1, "R6 add reg,mem traps");
    run_insn(1, 17, 1, 2, 1, 0, 1, "R6 other class traps");
    run_insn(1, 13, 5, 0, 1, 0, 1, "R6 not reg traps");
    run_insn(1, 5, 0, 1, 1, 0, 1, "R6 xchg reg,reg traps");

    run_insn(0, 5, 1, 1, 2, 1, 0, "R7 xchg mem implicit");
    run_insn(0, 5, 3, 0, 1, 1, 0, "R7 xchg reg,mem implicit");

    run_insn(1, 0, 0, 0, 0, 0, 1, "R8 real mode interrupt");
    run_insn(1, 0, 0, 2, 0, 0, 1, "R8 v86 fault");
    run_insn(1, 0, 0, 3, 0, 0, 1, "R8 mode 3 fault");

    // R9: locked insn done in the same cycle a plain insn starts
    @(negedge clk); pfx_vld = 1; pfx_byte = 8'hF0;
    @(negedge clk); pfx_vld = 0; insn_start = 1; op_class = 5'd7; op_form = 3'd1;
    @(negedge clk); insn_start = 0;
    chk(bus_lock_n == 1'b0, "R9 first locked", bus_lock_n, 0);
    insn_done = 1; insn_start = 1; op_class = 5'd17; op_form = 3'd1;
    @(negedge clk); insn_done = 0; insn_start = 0;
    chk(bus_lock_n == 1'b1, "R9 not carried", bus_lock_n, 1);
    // R9: back-to-back where the second also qualifies
    insn_done = 1; insn_start = 1; op_class = 5'd5; op_form = 3'd1;
    @(negedge clk); insn_done = 0; insn_start = 0;
    chk(bus_lock_n == 1'b0, "R9 second qualifies", bus_lock_n, 0);
    insn_done = 1; @(negedge clk); insn_done = 0;

    run_insn(0, 6, 1, 1, 1, 0, 0, "R10 add without prefix");
    run_insn(0, 17, 0, 0, 1, 0, 0, "R10 other without prefix");

    // mixed stimulus, checked against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      pfx_vld    = ($urandom % 4) == 0;
      pfx_byte   = (($urandom % 2) == 0) ? 8'hF0 : 8'($urandom);
      insn_start = ($urandom % 3) == 0;
      op_class   = 5'($urandom % 20);
      op_form    = 3'($urandom);
      cpu_mode   = 2'($urandom);
      insn_done  = ($urandom % 3) == 0;
      if (($urandom % 500) == 0) rst_n = 0; else rst_n = 1;
    end
    @(negedge clk);
    pfx_vld = 0; insn_start = 0; insn_done = 0; rst_n = 1;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule